// File: doc/BRIEF.md
# Wavefront Execute-Mask and Condition Controller

This block keeps the per-lane execute mask and the per-lane vector condition for a single wavefront of 64 work items. Divergent if/else code runs through a short series of scalar micro-ops sent to this block. A compare result is latched into the condition. The live mask is parked in one of four save slots. The mask is then narrowed to the taken lanes, flipped to the not-taken lanes for the else arm, and restored from the slot at the join point. No hardware reconvergence stack is involved: all divergence is plain 64-bit mask arithmetic.

Two zero flags let the sequencer skip an arm of the branch when no lane would run it. One flag tests the condition and one tests the execute mask. The live mask also gates the per-lane vector register write requests, so a lane whose mask bit is clear never writes.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset the execute mask is all ones, the condition is all zeros, `exec_zero` is 0 and `cond_zero` is 1.
- R2: Op code 1 (load condition) copies `cmp_result` into the condition register at the clock edge. The execute mask is unchanged.
- R3: Op code 2 (save) copies the execute mask into the save slot chosen by `slot_idx`. The execute mask and condition are unchanged.
- R4: Op code 3 (enter if-arm) sets the execute mask to condition AND execute mask.
- R5: Op code 4 (enter else-arm) sets the execute mask to the selected save slot AND NOT the current execute mask.
- R6: Op code 5 (restore) sets the execute mask to the contents of the selected save slot.
- R7: `cond_zero` is 1 exactly when the condition register is all zeros, and it is valid in the same cycle as the updated register.
- R8: `exec_zero` is 1 exactly when the execute mask is all zeros, and it is valid in the same cycle as the updated register.
- R9: `lane_wr_en` bit i equals `lane_wr_req` bit i AND execute-mask bit i.
- R10: The four save slots hold their values independently, so nested regions using different slots restore correctly.
- R11: Op code 0 (idle) and the unused codes 6 and 7 change neither the execute mask nor the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Micro-op: 0 idle, 1 load condition, 2 save, 3 if-arm, 4 else-arm, 5 restore |
| slot_idx | input | 2 | Save slot selected by save, else-arm and restore |
| cmp_result | input | 64 | Per-lane compare outcome |
| lane_wr_req | input | 64 | Per-lane vector register write requests |
| exec_mask | output | 64 | Current execute mask |
| cond_mask | output | 64 | Current condition register |
| exec_zero | output | 1 | Execute mask is all zeros |
| cond_zero | output | 1 | Condition is all zeros |
| lane_wr_en | output | 64 | Write requests gated by the execute mask |

## Verification
A corrupted mask shows up on `exec_mask` and `lane_wr_en` in the cycle after the faulty op. A wrong slot write only becomes visible later, at the restore or else-arm op that reads that slot, so the tests pair every save with a read-back through those ops. A flag that is computed from a stale or next-state value differs from the registered mask in exactly one cycle. For that reason the flags are sampled in the same cycle as the registers they describe.

// File: rtl/emc_pkg.sv
package emc_pkg;
    localparam int LANES     = 64;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int OP_W      = 3;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE     = 3'd0,
        OP_LD_COND  = 3'd1,
        OP_SAVE     = 3'd2,
        OP_IF_ARM   = 3'd3,
        OP_ELSE_ARM = 3'd4,
        OP_RESTORE  = 3'd5
    } emc_op_e;

    typedef struct packed {
        lane_mask_t exec;
        lane_mask_t cond;
    } mask_state_t;

    function automatic lane_mask_t all_lanes();
        return '1;
    endfunction

    function automatic logic is_known_op(logic [OP_W-1:0] code);
        return code <= OP_W'(OP_RESTORE);
    endfunction
endpackage

// File: rtl/emc_slot_bank.sv
module emc_slot_bank
    import emc_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [IW-1:0] idx,
    input  lane_mask_t wr_data,
    output lane_mask_t rd_data
);
    lane_mask_t slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (wr_en && (idx == IW'(s))) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[idx];
endmodule

// File: rtl/emc_zero_detect.sv
module emc_zero_detect #(
    parameter int W = 64
) (
    input  logic [W-1:0] vec,
    output logic         is_zero
);
    assign is_zero = ~|vec;
endmodule

// File: rtl/emc_mask_unit.sv
module emc_mask_unit
    import emc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [OP_W-1:0] op_code,
    input  lane_mask_t  cmp_result,
    input  lane_mask_t  slot_rd,
    output mask_state_t state_q
);
    mask_state_t state_d;
    emc_op_e     op;

    always_comb begin
        op      = emc_op_e'(op_code);
        state_d = state_q;
        if (is_known_op(op_code)) begin
            unique case (op)
                OP_LD_COND:  state_d.cond = cmp_result;
                OP_IF_ARM:   state_d.exec = state_q.cond & state_q.exec;
                OP_ELSE_ARM: state_d.exec = slot_rd & ~state_q.exec;
                OP_RESTORE:  state_d.exec = slot_rd;
                default:     state_d      = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.exec <= all_lanes();
            state_q.cond <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl
    import emc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_code,
    input  logic [1:0]         slot_idx,
    input  logic [63:0]        cmp_result,
    input  logic [63:0]        lane_wr_req,
    output logic [63:0]        exec_mask,
    output logic [63:0]        cond_mask,
    output logic               exec_zero,
    output logic               cond_zero,
    output logic [63:0]        lane_wr_en
);
    mask_state_t st;
    lane_mask_t  slot_rd;
    logic        save_en;

    assign save_en = (op_code == OP_SAVE);

    emc_slot_bank #(.SLOTS(NUM_SLOTS)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (save_en),
        .idx     (slot_idx),
        .wr_data (st.exec),
        .rd_data (slot_rd)
    );

    emc_mask_unit u_mask (
        .clk        (clk),
        .rst        (rst),
        .op_code    (op_code),
        .cmp_result (cmp_result),
        .slot_rd    (slot_rd),
        .state_q    (st)
    );

    emc_zero_detect #(.W(LANES)) u_exec_zd (.vec(st.exec), .is_zero(exec_zero));
    emc_zero_detect #(.W(LANES)) u_cond_zd (.vec(st.cond), .is_zero(cond_zero));

    assign exec_mask  = st.exec;
    assign cond_mask  = st.cond;
    assign lane_wr_en = lane_wr_req & st.exec;
endmodule

// File: rtl/emc_chk.sv
module emc_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_code,
    input logic [63:0] cmp_result,
    input logic [63:0] lane_wr_req,
    input logic [63:0] exec_mask,
    input logic [63:0] cond_mask,
    input logic        exec_zero,
    input logic        cond_zero,
    input logic [63:0] lane_wr_en
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (exec_mask == '1 && cond_mask == '0));
    // R2
    load_cond_chk: assert property (@(posedge clk) disable iff (rst)
        op_code == 3'd1 |=> (cond_mask == $past(cmp_result) && exec_mask == $past(exec_mask)));
    // R4
    if_arm_chk: assert property (@(posedge clk) disable iff (rst)
        op_code == 3'd3 |=> exec_mask == ($past(cond_mask) & $past(exec_mask)));
    // R8
    exec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        exec_zero == ($countones(exec_mask) == 0));
    // R7
    cond_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cond_zero == ($countones(cond_mask) == 0));
    // R9
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((lane_wr_en & ~exec_mask) == '0) && ((lane_wr_en ^ lane_wr_req) & exec_mask) == '0);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd0 || op_code > 3'd5) |=> ($stable(exec_mask) && $stable(cond_mask)));
endmodule

bind exec_mask_ctrl emc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_code     (op_code),
    .cmp_result  (cmp_result),
    .lane_wr_req (lane_wr_req),
    .exec_mask   (exec_mask),
    .cond_mask   (cond_mask),
    .exec_zero   (exec_zero),
    .cond_zero   (cond_zero),
    .lane_wr_en  (lane_wr_en)
);

// File: tb/exec_mask_ctrl_tb.sv
module exec_mask_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = '0;
    logic [1:0]  slot_idx = '0;
    logic [63:0] cmp_result = '0;
    logic [63:0] lane_wr_req = '0;
    logic [63:0] exec_mask, cond_mask, lane_wr_en;
    logic        exec_zero, cond_zero;
    int checks = 0;
    int errors = 0;

    localparam logic [63:0] ONES = '1;
    localparam logic [63:0] PA = 64'hF0F0_1234_0000_FFFF;
    localparam logic [63:0] PB = 64'h0FF0_0F0F_8001_00F0;

    always #4 clk = ~clk;

    exec_mask_ctrl u_dut (
        .clk(clk), .rst(rst), .op_code(op_code), .slot_idx(slot_idx),
        .cmp_result(cmp_result), .lane_wr_req(lane_wr_req),
        .exec_mask(exec_mask), .cond_mask(cond_mask),
        .exec_zero(exec_zero), .cond_zero(cond_zero), .lane_wr_en(lane_wr_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive op for one edge, return at the following negedge with results visible.
    task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [63:0] cmp);
        @(negedge clk);
        op_code = op; slot_idx = idx; cmp_result = cmp;
        @(negedge clk);
        op_code = 3'd0;
    endtask

    task automatic t_reset();
        chk("R1 exec", exec_mask, ONES);
        chk("R1 cond", cond_mask, '0);
        chk("R1 exec_zero", 64'(exec_zero), 64'd0);
        chk("R1 cond_zero", 64'(cond_zero), 64'd1);
    endtask

    task automatic t_if_else();
        issue(3'd1, 2'd0, PA);
        chk("R2 cond loaded", cond_mask, PA);
        chk("R2 exec kept", exec_mask, ONES);
        chk("R7 cond_zero low", 64'(cond_zero), 64'd0);
        issue(3'd2, 2'd0, '0);
        chk("R3 exec kept", exec_mask, ONES);
        chk("R3 cond kept", cond_mask, PA);
        issue(3'd3, 2'd0, '0);
        chk("R4 if-arm", exec_mask, PA);
        issue(3'd4, 2'd0, '0);
        chk("R5 else-arm", exec_mask, ~PA);
        issue(3'd5, 2'd0, '0);
        chk("R6 restore", exec_mask, ONES);
    endtask

    task automatic t_zero_cond();
        issue(3'd1, 2'd0, '0);
        chk("R7 cond_zero same cycle", 64'(cond_zero), 64'd1);
        issue(3'd3, 2'd0, '0);
        chk("R4 if-arm empty", exec_mask, '0);
        chk("R8 exec_zero same cycle", 64'(exec_zero), 64'd1);
        issue(3'd5, 2'd0, '0);
        chk("R8 exec_zero clears", 64'(exec_zero), 64'd0);
    endtask

    task automatic t_empty_else();
        issue(3'd1, 2'd0, ONES);
        issue(3'd2, 2'd3, '0);
        issue(3'd3, 2'd0, '0);
        chk("R4 all taken", exec_mask, ONES);
        issue(3'd4, 2'd3, '0);
        chk("R5 else empty", exec_mask, '0);
        chk("R8 else skip flag", 64'(exec_zero), 64'd1);
        issue(3'd5, 2'd3, '0);
        chk("R6 restore slot3", exec_mask, ONES);
    endtask

    task automatic t_nested();
        // outer: slot1 holds ONES, mask -> PA; inner: slot2 holds PA, mask -> PA&PB
        issue(3'd1, 2'd0, PA);
        issue(3'd2, 2'd1, '0);
        issue(3'd3, 2'd0, '0);
        issue(3'd1, 2'd0, PB);
        issue(3'd2, 2'd2, '0);
        issue(3'd3, 2'd0, '0);
        chk("R4 nested if", exec_mask, PA & PB);
        issue(3'd4, 2'd2, '0);
        chk("R10 inner else", exec_mask, PA & ~(PA & PB));
        issue(3'd5, 2'd2, '0);
        chk("R10 inner restore", exec_mask, PA);
        issue(3'd4, 2'd1, '0);
        chk("R10 outer else", exec_mask, ~PA);
        issue(3'd5, 2'd1, '0);
        chk("R10 outer restore", exec_mask, ONES);
    endtask

    task automatic t_gating();
        issue(3'd1, 2'd0, PB);
        issue(3'd2, 2'd0, '0);
        issue(3'd3, 2'd0, '0);
        lane_wr_req = ONES;
        #1 chk("R9 gate all-req", lane_wr_en, PB);
        lane_wr_req = PA;
        #1 chk("R9 gate pattern", lane_wr_en, PA & PB);
        lane_wr_req = '0;
        issue(3'd5, 2'd0, '0);
    endtask

    task automatic t_ignored();
        issue(3'd1, 2'd0, PA);
        issue(3'd3, 2'd0, '0);
        for (int c = 6; c < 8; c++) begin
            issue(3'(c), 2'd0, PB);
            chk("R11 unused op exec", exec_mask, PA);
            chk("R11 unused op cond", cond_mask, PA);
        end
        issue(3'd0, 2'd0, PB);
        chk("R11 idle exec", exec_mask, PA);
        chk("R11 idle cond", cond_mask, PA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_if_else();
        t_zero_cond();
        t_empty_else();
        t_nested();
        t_gating();
        t_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule